// File: doc/BRIEF.md
# Segmented Address Translation Front End

This block is the first stage of a memory management unit. Each request carries a 32-bit virtual address, an access kind (read, write or execute) and a user-mode flag. In the same cycle it decides one of three routes. The first is bypass, where translation is off. The second is segment mapping, a direct kernel-only remap of a 256 MB region through a 4-bit physical base. The third is paged, where the request is handed to the TLB lookup stage. It also tells the next stage whether the instruction TLB or the data TLB applies. The configuration registers arrive as plain input pins, and the TLB itself lies outside this block.

The datapath has no registers. A request offered on the `in_*` stream goes to one of two sinks. Bypass and segment results leave on the `res_*` stream, carrying the physical address and full permissions. Paged requests leave on the `tlb_*` stream. Back-pressure follows the route: `in_ready` copies the ready of the sink that the current request selects, and the sink that is not selected sees no valid. A request is consumed in the cycle where `in_valid` and `in_ready` are both high. The sinks must not make their ready depend on their own valid.

Top module: `segx_front`

## Requirements
- R1: When both translation-mode bits (`xlat_mode`, corresponding to global configuration bits 3 and 2) are zero, the route is bypass. In that case `res_paddr` equals `in_vaddr` and `res_perm` is 3'b111, for any privilege and any access kind.
- R2: If either translation-mode bit is set, translation is on and no request takes the bypass route.
- R3: The segment number is `in_vaddr[31:28]`. A kernel request (`in_user`=0) whose segment bit `seg_en[n]` is set takes the segment route.
- R4: The base nibble for segments 0 to 7 is `base_lo[4*n+3:4*n]`. For segments 8 to 15 it is `base_hi[4*(n-8)+3:4*(n-8)]`.
- R5: On the segment route, `res_paddr` is {base nibble, `in_vaddr[27:0]`} and `res_perm` is 3'b111 (bit 2 read, bit 1 write, bit 0 execute).
- R6: With translation on, a user request (`in_user`=1) always takes the paged route, even when its segment bit is set.
- R7: With translation on, a kernel request whose segment bit is clear takes the paged route.
- R8: `tlb_insn` is 1 exactly when `in_kind` is 2'b10 (execute). Kinds 2'b00 (read), 2'b01 (write) and 2'b11 (treated as read) select the data TLB.
- R9: `route` is always one-hot: bit 0 bypass, bit 1 segment, bit 2 paged. On the paged route `res_paddr` and `res_perm` are zero.
- R10: `res_valid` equals `in_valid` on bypass or segment routes and is 0 on the paged route. `tlb_valid` equals `in_valid` on the paged route and is 0 otherwise. `in_ready` follows `res_ready` or `tlb_ready` to match.
- R11: `tlb_vaddr`, `tlb_kind` and `tlb_user` repeat the request fields unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | 1 | Request valid |
| in_ready | output | 1 | Request accepted by the selected sink |
| in_vaddr | input | 32 | Virtual address |
| in_kind | input | 2 | 00 read, 01 write, 10 execute, 11 read |
| in_user | input | 1 | 1 for a user-mode access |
| xlat_mode | input | 2 | Translation enable bits; both zero means off |
| seg_en | input | 16 | Bit n enables direct mapping of segment n |
| base_lo | input | 32 | Base nibbles for segments 0 to 7 |
| base_hi | input | 32 | Base nibbles for segments 8 to 15 |
| res_valid | output | 1 | Direct result valid |
| res_ready | input | 1 | Direct result sink ready |
| res_paddr | output | 32 | Physical address of a direct result |
| res_perm | output | 3 | Permissions {read, write, execute} |
| route | output | 3 | One-hot route {paged, segment, bypass} |
| tlb_valid | output | 1 | Paged lookup request valid |
| tlb_ready | input | 1 | TLB stage ready |
| tlb_vaddr | output | 32 | Address forwarded to the TLB |
| tlb_kind | output | 2 | Access kind forwarded |
| tlb_user | output | 1 | Privilege forwarded |
| tlb_insn | output | 1 | 1 selects the instruction TLB |

## Verification
The bench walks all 16 segments with the enable bit set and clear, in both privilege modes. A design that swaps the two base registers, picks the wrong nibble position or lets a user access use the segment route therefore returns a wrong address or a wrong route. The translation-mode bits are probed one at a time and both clear, which catches a design that tests only one of the bits. Back-pressure is tested by holding the unselected sink's ready at the opposite level. A design that wires `in_ready` to the wrong sink, or raises both valids, then shows the wrong handshake. The execute and the 2'b11 kinds are checked against the TLB select.

// File: rtl/segx_pkg.sv
package segx_pkg;
  typedef enum logic [2:0] {
    RT_BYPASS = 3'b001,
    RT_SEG    = 3'b010,
    RT_PAGED  = 3'b100
  } route_e;

  localparam logic [1:0] KIND_RD = 2'b00;
  localparam logic [1:0] KIND_WR = 2'b01;
  localparam logic [1:0] KIND_EX = 2'b10;

  localparam logic [2:0] PERM_ALL  = 3'b111;
  localparam logic [2:0] PERM_NONE = 3'b000;
endpackage

// File: rtl/segx_base_sel.sv
module segx_base_sel #(
  parameter int SEG_W  = 4,
  localparam int NSEG  = 1 << SEG_W,
  localparam int HALF  = NSEG / 2,
  localparam int BANK_W = HALF * SEG_W
) (
  input  logic [SEG_W-1:0]  seg,
  input  logic [BANK_W-1:0] bank_lo,
  input  logic [BANK_W-1:0] bank_hi,
  output logic [SEG_W-1:0]  nibble
);
  logic [SEG_W-1:0] table_q [NSEG];

  for (genvar s = 0; s < NSEG; s++) begin : g_nib
    if (s < HALF) begin : g_lo
      assign table_q[s] = bank_lo[s*SEG_W +: SEG_W];
    end else begin : g_hi
      assign table_q[s] = bank_hi[(s-HALF)*SEG_W +: SEG_W];
    end
  end

  assign nibble = table_q[seg];
endmodule

// File: rtl/segx_route.sv
module segx_route #(
  parameter int SEG_W = 4,
  localparam int NSEG = 1 << SEG_W
) (
  input  logic [1:0]       mode,
  input  logic [SEG_W-1:0] seg,
  input  logic [NSEG-1:0]  seg_en,
  input  logic             user,
  input  logic [1:0]       kind,
  output segx_pkg::route_e rt,
  output logic             insn
);
  import segx_pkg::*;
  logic xlat_on;
  logic seg_hit;

  assign xlat_on = |mode;
  assign seg_hit = seg_en[seg] & ~user;
  assign insn    = (kind == KIND_EX);

  always_comb begin
    if (!xlat_on)     rt = RT_BYPASS;
    else if (seg_hit) rt = RT_SEG;
    else              rt = RT_PAGED;
  end
endmodule

// File: rtl/segx_front.sv
module segx_front #(
  parameter int ADDR_W = 32,
  parameter int SEG_W  = 4,
  localparam int NSEG   = 1 << SEG_W,
  localparam int BANK_W = (NSEG / 2) * SEG_W,
  localparam int OFF_W  = ADDR_W - SEG_W
) (
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [ADDR_W-1:0] in_vaddr,
  input  logic [1:0]        in_kind,
  input  logic              in_user,
  input  logic [1:0]        xlat_mode,
  input  logic [NSEG-1:0]   seg_en,
  input  logic [BANK_W-1:0] base_lo,
  input  logic [BANK_W-1:0] base_hi,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [ADDR_W-1:0] res_paddr,
  output logic [2:0]        res_perm,
  output logic [2:0]        route,
  output logic              tlb_valid,
  input  logic              tlb_ready,
  output logic [ADDR_W-1:0] tlb_vaddr,
  output logic [1:0]        tlb_kind,
  output logic              tlb_user,
  output logic              tlb_insn
);
  import segx_pkg::*;

  logic [SEG_W-1:0] seg_num;
  logic [SEG_W-1:0] seg_base;
  logic [OFF_W-1:0] seg_off;
  route_e           rt;

  assign seg_num = in_vaddr[ADDR_W-1 -: SEG_W];
  assign seg_off = in_vaddr[OFF_W-1:0];

  segx_base_sel #(.SEG_W(SEG_W)) u_base (
    .seg     (seg_num),
    .bank_lo (base_lo),
    .bank_hi (base_hi),
    .nibble  (seg_base)
  );

  segx_route #(.SEG_W(SEG_W)) u_route (
    .mode   (xlat_mode),
    .seg    (seg_num),
    .seg_en (seg_en),
    .user   (in_user),
    .kind   (in_kind),
    .rt     (rt),
    .insn   (tlb_insn)
  );

  always_comb begin
    unique case (rt)
      RT_BYPASS: begin
        res_paddr = in_vaddr;
        res_perm  = PERM_ALL;
      end
      RT_SEG: begin
        res_paddr = {seg_base, seg_off};
        res_perm  = PERM_ALL;
      end
      default: begin
        res_paddr = '0;
        res_perm  = PERM_NONE;
      end
    endcase
  end

  assign route     = rt;
  assign res_valid = in_valid & (rt != RT_PAGED);
  assign tlb_valid = in_valid & (rt == RT_PAGED);
  assign in_ready  = (rt == RT_PAGED) ? tlb_ready : res_ready;
  assign tlb_vaddr = in_vaddr;
  assign tlb_kind  = in_kind;
  assign tlb_user  = in_user;
endmodule

// File: rtl/segx_front_chk.sv
module segx_front_chk (
  input logic        in_valid,
  input logic        in_ready,
  input logic [31:0] in_vaddr,
  input logic        in_user,
  input logic [1:0]  xlat_mode,
  input logic        res_valid,
  input logic        res_ready,
  input logic [31:0] res_paddr,
  input logic [2:0]  res_perm,
  input logic [2:0]  route,
  input logic        tlb_valid,
  input logic        tlb_ready
);
  always_comb begin
    p_route_onehot_r9: assert ($onehot(route));
    p_sink_excl_r10: assert (!(res_valid && tlb_valid));
    if (xlat_mode == 2'b00) begin
      p_bypass_ident_r1: assert (res_paddr == in_vaddr && res_perm == 3'b111);
    end
    if (xlat_mode != 2'b00) begin
      p_no_bypass_r2: assert (route[0] == 1'b0);
    end
    if (route[1]) begin
      p_seg_offset_r5: assert (res_paddr[27:0] == in_vaddr[27:0] && res_perm == 3'b111);
    end
    if (in_user && xlat_mode != 2'b00) begin
      p_user_paged_r6: assert (route[2]);
    end
    if (in_valid && tlb_valid) begin
      p_ready_follow_r10: assert (in_ready == tlb_ready);
    end
    if (in_valid && res_valid) begin
      p_ready_res_r10: assert (in_ready == res_ready);
    end
  end
endmodule

bind segx_front segx_front_chk u_chk (
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_vaddr  (in_vaddr),
  .in_user   (in_user),
  .xlat_mode (xlat_mode),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_paddr (res_paddr),
  .res_perm  (res_perm),
  .route     (route),
  .tlb_valid (tlb_valid),
  .tlb_ready (tlb_ready)
);

// File: tb/sim_segx_front.sv
module sim_segx_front;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        in_valid, in_ready, in_user, res_valid, res_ready, tlb_valid, tlb_ready;
  logic        tlb_user, tlb_insn;
  logic [31:0] in_vaddr, base_lo, base_hi, res_paddr, tlb_vaddr;
  logic [1:0]  in_kind, xlat_mode, tlb_kind;
  logic [15:0] seg_en;
  logic [2:0]  res_perm, route;

  segx_front u0 (
    .in_valid(in_valid), .in_ready(in_ready), .in_vaddr(in_vaddr), .in_kind(in_kind),
    .in_user(in_user), .xlat_mode(xlat_mode), .seg_en(seg_en), .base_lo(base_lo),
    .base_hi(base_hi), .res_valid(res_valid), .res_ready(res_ready),
    .res_paddr(res_paddr), .res_perm(res_perm), .route(route), .tlb_valid(tlb_valid),
    .tlb_ready(tlb_ready), .tlb_vaddr(tlb_vaddr), .tlb_kind(tlb_kind),
    .tlb_user(tlb_user), .tlb_insn(tlb_insn)
  );

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam logic [31:0] LO = 32'h3C5A_9E17;
  localparam logic [31:0] HI = 32'hB4D2_0F86;

  typedef struct packed {
    logic [31:0] va;
    logic [1:0]  kind;
    logic        user;
    logic [1:0]  mode;
    logic [15:0] mask;
    logic [2:0]  rt;
    logic [31:0] pa;
    logic        insn;
  } vec_t;

  localparam vec_t TBL [8] = '{
    '{32'hDEAD_BEEF, 2'b00, 1'b0, 2'b00, 16'hFFFF, 3'b001, 32'hDEAD_BEEF, 1'b0},
    '{32'h3123_4567, 2'b01, 1'b0, 2'b10, 16'h0008, 3'b010, 32'h9123_4567, 1'b0},
    '{32'hA000_0010, 2'b10, 1'b0, 2'b01, 16'h0400, 3'b010, 32'hF000_0010, 1'b1},
    '{32'hA000_0010, 2'b00, 1'b1, 2'b11, 16'hFFFF, 3'b100, 32'h0000_0000, 1'b0},
    '{32'h8765_4321, 2'b10, 1'b1, 2'b00, 16'hFFFF, 3'b001, 32'h8765_4321, 1'b1},
    '{32'hF000_0000, 2'b01, 1'b0, 2'b10, 16'h7FFF, 3'b100, 32'h0000_0000, 1'b0},
    '{32'h0FFF_FFFF, 2'b00, 1'b0, 2'b10, 16'h0001, 3'b010, 32'h7FFF_FFFF, 1'b0},
    '{32'h7ABC_DEF0, 2'b10, 1'b1, 2'b01, 16'h0000, 3'b100, 32'h0000_0000, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [31:0] va, input logic [1:0] k, input logic u,
                       input logic [1:0] m, input logic [15:0] msk);
    @(negedge clk);
    in_vaddr = va; in_kind = k; in_user = u; xlat_mode = m; seg_en = msk;
    #2;
  endtask

  function automatic logic [3:0] ref_nib(input int s);
    return (s < 8) ? LO[4*s +: 4] : HI[4*(s-8) +: 4];
  endfunction

  initial begin
    in_valid = 0; in_vaddr = '0; in_kind = 0; in_user = 0; xlat_mode = 0; seg_en = 0;
    base_lo = LO; base_hi = HI; res_ready = 1; tlb_ready = 1;
    repeat (3) @(posedge clk);
    #2;
    // idle state: R10 no valid without a request
    chk(!res_valid && !tlb_valid, "R10 idle", {res_valid, tlb_valid}, 0);

    in_valid = 1;
    for (int i = 0; i < 8; i++) begin
      drive(TBL[i].va, TBL[i].kind, TBL[i].user, TBL[i].mode, TBL[i].mask);
      // R1 R3 R5 R6 R7 route and address
      chk(route == TBL[i].rt && res_paddr == TBL[i].pa, "R1/R3/R5 table route+paddr",
          {route, res_paddr}, {TBL[i].rt, TBL[i].pa});
      // R9 perm
      chk(res_perm == (TBL[i].rt[2] ? 3'b000 : 3'b111), "R9 table perm",
          res_perm, TBL[i].rt[2] ? 3'b000 : 3'b111);
      // R8 insn select
      chk(tlb_insn == TBL[i].insn, "R8 table tlb_insn", tlb_insn, TBL[i].insn);
      // R10 valid routing
      chk(res_valid == !TBL[i].rt[2] && tlb_valid == TBL[i].rt[2], "R10 table valids",
          {res_valid, tlb_valid}, {!TBL[i].rt[2], TBL[i].rt[2]});
    end

    // R2: each mode bit alone enables translation
    drive(32'h1234_5678, 2'b00, 1'b0, 2'b01, 16'h0000);
    chk(route == 3'b100, "R2 mode bit2", route, 3'b100);
    drive(32'h1234_5678, 2'b00, 1'b0, 2'b10, 16'h0000);
    chk(route == 3'b100, "R2 mode bit3", route, 3'b100);

    // R8: kind 11 selects data TLB
    drive(32'h1234_5678, 2'b11, 1'b0, 2'b10, 16'h0000);
    chk(tlb_insn == 1'b0, "R8 kind11", tlb_insn, 0);

    // R11: forwarded fields
    drive(32'h5EAD_1234, 2'b01, 1'b1, 2'b10, 16'hFFFF);
    chk(tlb_vaddr == 32'h5EAD_1234 && tlb_kind == 2'b01 && tlb_user == 1'b1,
        "R11 forward", {tlb_vaddr, tlb_kind, tlb_user}, {32'h5EAD_1234, 2'b01, 1'b1});

    // R10: back-pressure follows the selected sink
    res_ready = 1; tlb_ready = 0; #1;
    chk(in_ready == 1'b0, "R10 paged stall", in_ready, 0);
    tlb_ready = 1; res_ready = 0; #1;
    chk(in_ready == 1'b1, "R10 paged go", in_ready, 1);
    drive(32'h3000_0000, 2'b00, 1'b0, 2'b10, 16'h0008);
    chk(in_ready == 1'b0, "R10 seg stall", in_ready, 0);
    res_ready = 1; tlb_ready = 0; #1;
    chk(in_ready == 1'b1, "R10 seg go", in_ready, 1);
    tlb_ready = 1;

    // R3 R4 R5 R6 R7: every segment, enable set and clear, both privileges
    for (int s = 0; s < 16; s++) begin
      for (int en = 0; en < 2; en++) begin
        for (int u = 0; u < 2; u++) begin
          logic [31:0] va, epa;
          logic [2:0]  ert;
          va = {s[3:0], 28'h5A5_C3E1};
          if (en == 1 && u == 0) begin
            ert = 3'b010; epa = {ref_nib(s), 28'h5A5_C3E1};
          end else begin
            ert = 3'b100; epa = 32'h0;
          end
          drive(va, 2'b00, u[0], 2'b10, en[0] ? (16'h1 << s) : ~(16'h1 << s));
          chk(route == ert && res_paddr == epa, "R4/R6/R7 segment sweep",
              {route, res_paddr}, {ert, epa});
        end
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule